// File: doc/BRIEF.md
# Early-Terminating Radix-4 Booth Multiply-Accumulate Unit

This block multiplies two 32-bit operands over several clock cycles and keeps the low 32 bits of the product. It can add a third 32-bit operand to the product. The multiplier operand is retired two bits per cycle using radix-4 Booth recoding. Each Booth digit is taken from a bit pair and the bit just below that pair, and the bit below bit 0 is treated as zero. The operation stops as soon as the multiplier bits not yet consumed are all zero. As a result, a short multiplier finishes in a few cycles, while a multiplier with ones in its top bits needs the full sixteen groups.

A client pulses `start_i` while the unit is idle. At that edge the unit captures the multiplicand, the multiplier, the accumulate operand and two control bits, and loads the partial sum with the accumulate operand (or zero). This is the setup cycle. Every later cycle adds one recoded term. On the last group the unit publishes the sum on `result_o`, pulses `done_o` for one cycle and returns to idle. If flag update was requested, it also refreshes a negative flag and a zero flag from the new result. Only the low word is kept, so the same hardware serves signed and unsigned operands.

Top module: `booth_mac_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o`, `done_o`, `neg_o`, `zero_o` and `result_o` are all zero.
- R2: A high `start_i` sampled while `busy_o` is low is accepted, and `busy_o` is high in the following cycle.
- R3: Define g as the smallest k from 1 to 16 for which the multiplier shifted right by 2k is zero and multiplier bit 2k-1 is zero; if no such k exists, g is 16. If a start is accepted at edge e, then `busy_o` stays high through edge e+g-1 and `done_o` rises at edge e+g. The whole operation therefore spans 1+g cycles: multiplicand 18 with multiplier 0xFFFFFFFF takes 17 cycles, and multiplicand 0xFFFFFFFF with multiplier 18 takes 4.
- R4: At completion, `result_o` equals (multiplicand × multiplier + addend) mod 2^32. The addend is the accumulate operand when accumulate was enabled at start, and zero otherwise. The value is the same whether the operands are read as signed or unsigned.
- R5: `done_o` is high for exactly one cycle per operation. `result_o` holds its value until the next completion.
- R6: A high `start_i` while `busy_o` is high is ignored. The running operation keeps its operands, its result and its timing, and no further operation follows it.
- R7: When flag update was requested at start, completion sets `neg_o` to result bit 31 and sets `zero_o` high exactly when the result is all zero.
- R8: When flag update was not requested, `neg_o` and `zero_o` keep their previous values through the operation and its completion.
- R9: With accumulate disabled, the value on `acc_i` has no effect on the result.
- R10: A zero multiplier completes after one group (2 cycles in all), and the result equals the addend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, honoured only when idle |
| mcand_i | input | 32 | Multiplicand |
| mplr_i | input | 32 | Multiplier, recoded two bits per cycle |
| acc_i | input | 32 | Accumulate operand |
| acc_en_i | input | 1 | Add `acc_i` to the product |
| set_flags_i | input | 1 | Update the negative and zero flags at completion |
| result_o | output | 32 | Low word of the last completed operation |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
`busy_o` is due one edge after the accepting edge. `done_o`, the new `result_o` and any flag change are all due g edges after that edge, where g depends on the multiplier's data. The bench keeps a behavioural model that tracks the g edges still outstanding and updates its expected outputs at each rising edge. Inputs are driven and every output is compared on the falling edge in between, so each edge's result is checked half a cycle after it is produced. Each directed operation also counts the falling edges from its start pulse to `done_o` and compares that count with 1+g, worked out from the multiplier on its own.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mac_state_e;

    // One radix-4 recoded digit: magnitude 0, 1 or 2 with a sign
    typedef struct packed {
        logic nz;   // digit is non-zero
        logic dbl;  // magnitude is two
        logic neg;  // digit is negative
    } booth_digit_t;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic [2:0]   triplet_i,   // {bit 2i+1, bit 2i, bit 2i-1}
    output booth_digit_t digit_o
);

    always_comb begin
        digit_o = '0;
        unique case (triplet_i)
            3'b000: digit_o = '{nz: 1'b0, dbl: 1'b0, neg: 1'b0};
            3'b001: digit_o = '{nz: 1'b1, dbl: 1'b0, neg: 1'b0};
            3'b010: digit_o = '{nz: 1'b1, dbl: 1'b0, neg: 1'b0};
            3'b011: digit_o = '{nz: 1'b1, dbl: 1'b1, neg: 1'b0};
            3'b100: digit_o = '{nz: 1'b1, dbl: 1'b1, neg: 1'b1};
            3'b101: digit_o = '{nz: 1'b1, dbl: 1'b0, neg: 1'b1};
            3'b110: digit_o = '{nz: 1'b1, dbl: 1'b0, neg: 1'b1};
            3'b111: digit_o = '{nz: 1'b0, dbl: 1'b0, neg: 1'b0};
            default: digit_o = '0;
        endcase
    end

endmodule

// File: rtl/booth_term.sv
module booth_term
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] mcand_i,   // multiplicand already aligned to the group
    input  booth_digit_t     digit_i,
    output logic [WIDTH-1:0] term_o
);

    logic [WIDTH-1:0] mag;

    always_comb begin
        mag = digit_i.dbl ? {mcand_i[WIDTH-2:0], 1'b0} : mcand_i;
        if (!digit_i.nz) begin
            term_o = '0;
        end else if (digit_i.neg) begin
            term_o = ~mag + {{(WIDTH-1){1'b0}}, 1'b1};
        end else begin
            term_o = mag;
        end
    end

endmodule

// File: rtl/booth_stop_detect.sv
module booth_stop_detect #(
    parameter int WIDTH  = 32,
    parameter int GROUPS = WIDTH / 2,
    parameter int CNT_W  = $clog2(GROUPS)
) (
    input  logic [WIDTH-1:0] mplr_i,   // multiplier bits not yet consumed, current group at [1:0]
    input  logic [CNT_W-1:0] cnt_i,    // index of the group being consumed
    output logic             last_o
);

    logic rest_zero;
    logic no_carry;
    logic at_cap;

    always_comb begin
        rest_zero = (mplr_i[WIDTH-1:2] == '0);
        no_carry  = ~mplr_i[1];
        at_cap    = (cnt_i == CNT_W'(GROUPS - 1));
        last_o    = (rest_zero && no_carry) || at_cap;
    end

endmodule

// File: rtl/booth_mac_unit.sv
module booth_mac_unit
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplr_i,
    input  logic [WIDTH-1:0] acc_i,
    input  logic             acc_en_i,
    input  logic             set_flags_i,
    output logic [WIDTH-1:0] result_o,
    output logic             neg_o,
    output logic             zero_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam int GROUPS = WIDTH / 2;
    localparam int CNT_W  = $clog2(GROUPS);

    typedef struct packed {
        mac_state_e       state;
        logic [WIDTH-1:0] mcand;
        logic [WIDTH-1:0] mplr;
        logic             prev;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] psum;
        logic             flags_en;
        logic [WIDTH-1:0] result;
        logic             neg;
        logic             zero;
        logic             done;
    } mac_regs_t;

    mac_regs_t        r_q, r_d;
    booth_digit_t     digit;
    logic [WIDTH-1:0] term;
    logic [WIDTH-1:0] psum_next;
    logic             last_grp;

    booth_recode u_recode (
        .triplet_i ({r_q.mplr[1:0], r_q.prev}),
        .digit_o   (digit)
    );

    booth_term #(.WIDTH(WIDTH)) u_term (
        .mcand_i (r_q.mcand),
        .digit_i (digit),
        .term_o  (term)
    );

    booth_stop_detect #(.WIDTH(WIDTH), .GROUPS(GROUPS), .CNT_W(CNT_W)) u_stop (
        .mplr_i (r_q.mplr),
        .cnt_i  (r_q.cnt),
        .last_o (last_grp)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        psum_next = r_q.psum + term;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state    = ST_RUN;
                    r_d.mcand    = mcand_i;
                    r_d.mplr     = mplr_i;
                    r_d.prev     = 1'b0;
                    r_d.cnt      = '0;
                    r_d.psum     = acc_en_i ? acc_i : '0;
                    r_d.flags_en = set_flags_i;
                end
            end
            ST_RUN: begin
                r_d.psum  = psum_next;
                r_d.mcand = {r_q.mcand[WIDTH-3:0], 2'b00};
                r_d.mplr  = {2'b00, r_q.mplr[WIDTH-1:2]};
                r_d.prev  = r_q.mplr[1];
                r_d.cnt   = r_q.cnt + CNT_W'(1);
                if (last_grp) begin
                    r_d.state  = ST_IDLE;
                    r_d.result = psum_next;
                    r_d.done   = 1'b1;
                    if (r_q.flags_en) begin
                        r_d.neg  = psum_next[WIDTH-1];
                        r_d.zero = (psum_next == '0);
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign result_o = r_q.result;
    assign neg_o    = r_q.neg;
    assign zero_o   = r_q.zero;
    assign busy_o   = (r_q.state == ST_RUN);
    assign done_o   = r_q.done;

    // R2: an idle start is taken
    p_accept_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R6: a start while running neither aborts nor restarts silently
    p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> (busy_o || done_o));

    // R5: completion pulse lasts a single cycle
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: leaving the running state always coincides with completion
    p_busy_ends_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R5: the published result changes only on completion
    p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R7: requested flags track the published result
    p_flags_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && r_q.flags_en) |->
            (neg_o == result_o[WIDTH-1]) && (zero_o == (result_o == '0)));

    // R8: flags move only on a completion that asked for them
    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && r_q.flags_en) |-> $stable({neg_o, zero_o}));

endmodule

// File: tb/booth_mac_unit_test.sv
module booth_mac_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] mc = '0, mp = '0, acc = '0;
    logic        en = 1'b0, sf = 1'b0;
    logic [31:0] result;
    logic        neg, zero, busy, done;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit summary_done = 1'b0;

    always #2 clk = ~clk;

    booth_mac_unit uut (
        .clk (clk), .rst_n (rst_n), .start_i (start),
        .mcand_i (mc), .mplr_i (mp), .acc_i (acc),
        .acc_en_i (en), .set_flags_i (sf),
        .result_o (result), .neg_o (neg), .zero_o (zero),
        .busy_o (busy), .done_o (done)
    );

    function automatic int groups_for(logic [31:0] m);
        for (int k = 1; k <= 16; k++) begin
            if (((m >> (2 * k)) == 32'd0) && (m[2 * k - 1] == 1'b0)) return k;
        end
        return 16;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // behavioural reference model, advanced on every rising edge
    bit          m_busy, m_done, m_n, m_z, m_sf, was_busy;
    logic [31:0] m_res, m_pend;
    int          m_left;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_n = 0; m_z = 0; m_res = '0; m_left = 0;
        end else begin
            was_busy = m_busy;
            m_done = 0;
            if (was_busy) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy = 0;
                    m_done = 1;
                    m_res = m_pend;
                    if (m_sf) begin
                        m_n = m_pend[31];
                        m_z = (m_pend == 32'd0);
                    end
                end
            end else if (start) begin
                m_busy = 1;
                m_left = groups_for(mp);
                m_pend = mc * mp + (en ? acc : 32'd0);
                m_sf = sf;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == m_busy, "R3 busy", 32'(busy), 32'(m_busy));
            check(done == m_done, "R5 done", 32'(done), 32'(m_done));
            check(result == m_res, "R4 result", result, m_res);
            check({neg, zero} == {m_n, m_z}, "R7/R8 flags", 32'({neg, zero}), 32'({m_n, m_z}));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !summary_done) begin
            summary_done = 1'b1;
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", cycles, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // start one operation, wait for done, return cycle count
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                          input bit e, input bit f, output int n);
        @(negedge clk);
        mc = a; mp = b; acc = c; en = e; sf = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic op_checked(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                              input bit e, input bit f, input string tag);
        int n;
        logic [31:0] exp;
        exp = a * b + (e ? c : 32'd0);
        run_op(a, b, c, e, f, n);
        check(n == 1 + groups_for(b), {tag, " R3 cycles"}, 32'(n), 32'(1 + groups_for(b)));
        check(result == exp, {tag, " R4 value"}, result, exp);
    endtask

    initial begin
        int n;
        logic [31:0] seed;
        repeat (3) @(negedge clk);
        check({busy, done, neg, zero} == 4'b0 && result == '0, "R1 reset", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, neg, zero} == 4'b0 && result == '0, "R1 after reset", result, 32'd0);

        // R2 start accepted from idle
        @(negedge clk);
        mc = 32'd7; mp = 32'd9; acc = '0; en = 0; sf = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", 32'(busy), 32'd1);
        while (!done) @(negedge clk);
        check(result == 32'd63, "R4 small product", result, 32'd63);

        // R3 data-dependent cycle counts
        run_op(32'd18, 32'hFFFF_FFFF, '0, 0, 0, n);
        check(n == 17, "R3 long multiplier cycles", 32'(n), 32'd17);
        check(result == 32'hFFFF_FFEE, "R4 18 x -1", result, 32'hFFFF_FFEE);
        run_op(32'hFFFF_FFFF, 32'd18, '0, 0, 0, n);
        check(n == 4, "R3 short multiplier cycles", 32'(n), 32'd4);
        check(result == 32'hFFFF_FFEE, "R4 -1 x 18", result, 32'hFFFF_FFEE);

        // R10 zero multiplier
        op_checked(32'h1234_5678, 32'd0, 32'h0000_0ABC, 1, 0, "R10 zero multiplier");
        check(result == 32'h0000_0ABC, "R10 result is addend", result, 32'h0000_0ABC);

        // R9 accumulate disabled ignores acc
        op_checked(32'd1000, 32'd3, 32'hDEAD_BEEF, 0, 0, "R9 acc off");
        check(result == 32'd3000, "R9 acc value ignored", result, 32'd3000);
        op_checked(32'd1000, 32'd3, 32'd5, 1, 0, "R4 acc on");

        // R7 flags: negative then zero
        op_checked(32'hFFFF_FFFE, 32'd5, '0, 0, 1, "R7 neg");
        check(neg == 1'b1 && zero == 1'b0, "R7 negative flags", 32'({neg, zero}), 32'b10);
        op_checked(32'd6, 32'd4, 32'hFFFF_FFE8, 1, 1, "R7 zero");
        check(neg == 1'b0 && zero == 1'b1, "R7 zero flags", 32'({neg, zero}), 32'b01);

        // R8 flags kept without request
        op_checked(32'hFFFF_FFF0, 32'd2, '0, 0, 0, "R8 no flags");
        check(neg == 1'b0 && zero == 1'b1, "R8 flags kept", 32'({neg, zero}), 32'b01);

        // R6 start while busy ignored
        @(negedge clk);
        mc = 32'd3; mp = 32'hFFFF_FFFF; acc = '0; en = 0; sf = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        repeat (3) begin @(negedge clk); n++; end
        mc = 32'd5; mp = 32'd1; acc = 32'd77; en = 1; sf = 1; start = 1'b1;
        @(negedge clk); n++;
        start = 1'b0;
        while (!done) begin @(negedge clk); n++; end
        check(n == 17, "R6 timing unchanged", 32'(n), 32'd17);
        check(result == 32'hFFFF_FFFD, "R6 result unchanged", result, 32'hFFFF_FFFD);
        repeat (4) begin
            @(negedge clk);
            check(!busy && !done, "R6 no follow-on op", 32'({busy, done}), 32'd0);
        end

        // R4/R3 varied patterns
        seed = 32'h1357_9BDF;
        for (int i = 0; i < 24; i++) begin
            logic [31:0] a, b, c;
            seed = seed * 32'd1103515245 + 32'd12345; a = seed;
            seed = seed * 32'd1103515245 + 32'd12345; b = seed >> (seed[4:0]);
            seed = seed * 32'd1103515245 + 32'd12345; c = seed;
            op_checked(a, b, c, seed[7], seed[9], "R4 pattern");
        end

        repeat (3) @(negedge clk);
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        end
        $finish;
    end

endmodule